// File: doc/BRIEF.md
# Logical Shift Unit with Legacy Flag Emulation

This block carries out a logical left shift or a logical right shift of a byte or word operand. It returns the shifted value together with a complete set of arithmetic status flags. The carry, overflow and auxiliary-carry flags copy the behaviour of an early 32-bit processor family. That family produces fixed, repeatable values for these flags even where the architecture leaves them undefined: shift counts at or beyond the operand width, and the auxiliary carry on any shift. An instruction-set emulator or a compatible core can use the block to reproduce that behaviour bit for bit.

Each operation is presented for one cycle with `in_valid`. The result and flags come back, registered, one cycle later with `out_valid`. Before use, the raw count is reduced to its low five bits. A reduced count of zero is a no-op for the flags.

Top module: `shift_flag_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. `result` and `flags_out` for that operation are presented in that same cycle.
- R2: Only bits [4:0] of `count` are used. When those bits are zero, `result` equals the operand (for a byte, the low byte with bits [15:8] zero) and `flags_out` equals `flags_in`.
- R3: `is_word`=1 selects a 16-bit operand and `is_word`=0 selects the 8-bit operand in bits [7:0]. `dir_right`=1 selects a logical right shift and 0 selects a left shift. The result is the operand shifted by the reduced count with zeros filled in. It is zero when the reduced count is at least the operand width, and bits [15:8] are always zero for byte operations.
- R4: For a nonzero reduced count, AF is 1 in both directions and at both sizes.
- R5: For a nonzero reduced count, SF is the result's top bit at the operand size, ZF is set when the result is zero, and PF is set when result bits [7:0] hold an even number of ones.
- R6: Where no rule from R7 to R11 applies, CF is the last bit shifted out (0 if that bit lay beyond the operand). OF is the original top bit for a right shift, and the new top bit XOR CF for a left shift.
- R7: A byte right shift by 8, 16 or 24 gives CF equal to original bit 7 and OF = 0.
- R8: A byte right shift by any other count above 8 clears both CF and OF.
- R9: A byte left shift by 8, 16 or 24 gives CF equal to original bit 0 and OF equal to that CF.
- R10: A byte left shift by any other count above 8 clears both CF and OF.
- R11: A word left shift by exactly 16 gives CF equal to original bit 0 and OF equal to CF. A word left shift by a count above 16 clears both.
- R12: The flag vector layout is bit 0 CF, bit 1 PF, bit 2 AF, bit 3 ZF, bit 4 SF, bit 5 OF. This applies to both `flags_in` and `flags_out`.
- R13: While `rst_n` is low, `out_valid`, `result` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| operand | input | 16 | Value to shift; bits [7:0] for byte operations |
| is_word | input | 1 | 1 = word, 0 = byte |
| dir_right | input | 1 | 1 = right shift, 0 = left shift |
| count | input | 8 | Raw shift count; low 5 bits used |
| flags_in | input | 6 | Incoming flags (layout in R12) |
| out_valid | output | 1 | Result and flags valid |
| result | output | 16 | Shifted value |
| flags_out | output | 6 | Updated flags (layout in R12) |

## Verification
The bench sweeps every reduced count from 0 to 31 in both directions and at both sizes, for operands chosen so that bit 0, bit 7 and bit 15 differ. A design that treated byte counts of 16 or 24 as plain "beyond width" would clear CF and OF and so miss R7 and R9. A design that used normal semantics for byte right shifts would leave OF at the original top bit. Raw counts with their upper bits set test the masking: a design that used the whole count would zero the result where the reduced count is small. Zero-count operations with arbitrary incoming flags catch any design that sets AF or recomputes SF, ZF or PF when no shift takes place.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    // Flag vector, bit 5 down to bit 0
    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } sfu_flags_t;

    localparam int FLAG_W = 6;

    // Even parity over a byte, as the parity flag defines it
    function automatic logic even_parity8(input logic [7:0] v);
        logic acc;
        acc = 1'b1;
        for (int i = 0; i < 8; i++) begin
            acc = acc ^ v[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/sfu_count_reduce.sv
module sfu_count_reduce #(
    parameter int CNT_W  = 8,
    parameter int MASK_W = 5
) (
    input  logic [CNT_W-1:0]  count_i,
    output logic [MASK_W-1:0] cnt_o,
    output logic              nonzero_o
);
    logic unused_hi;

    generate
        if (CNT_W > MASK_W) begin : g_trim
            assign unused_hi = ^count_i[CNT_W-1:MASK_W];
        end else begin : g_keep
            assign unused_hi = 1'b0;
        end
    endgenerate

    always_comb begin
        cnt_o     = count_i[MASK_W-1:0];
        nonzero_o = |count_i[MASK_W-1:0];
    end
endmodule

// File: rtl/sfu_shifter.sv
module sfu_shifter #(
    parameter int DATA_W = 16,
    parameter int MASK_W = 5
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic              is_word_i,
    input  logic              dir_right_i,
    input  logic [MASK_W-1:0] cnt_i,
    output logic [DATA_W-1:0] result_o,
    output logic              cf_o,
    output logic              of_o,
    output logic              op_lsb_o,
    output logic              op_bmsb_o
);
    localparam int SPAN   = 1 << MASK_W;
    localparam int EXT_W  = DATA_W + SPAN;
    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] opnd;
    logic [EXT_W-1:0]  left_x;
    logic [EXT_W-1:0]  right_x;
    logic              new_msb;
    logic              unused_ext;

    assign unused_ext = ^left_x[EXT_W-1:DATA_W+1] ^ ^right_x[SPAN-2:0];

    always_comb begin
        opnd    = is_word_i ? operand_i
                            : {{(DATA_W-BYTE_W){1'b0}}, operand_i[BYTE_W-1:0]};
        left_x  = {{SPAN{1'b0}}, opnd} << cnt_i;
        right_x = {opnd, {SPAN{1'b0}}} >> cnt_i;
        new_msb = 1'b0;
        if (dir_right_i) begin
            result_o = right_x[EXT_W-1 -: DATA_W];
            cf_o     = right_x[SPAN-1];
            of_o     = is_word_i ? opnd[DATA_W-1] : opnd[BYTE_W-1];
        end else begin
            result_o = is_word_i ? left_x[DATA_W-1:0]
                                 : {{(DATA_W-BYTE_W){1'b0}}, left_x[BYTE_W-1:0]};
            cf_o     = is_word_i ? left_x[DATA_W] : left_x[BYTE_W];
            new_msb  = is_word_i ? left_x[DATA_W-1] : left_x[BYTE_W-1];
            of_o     = new_msb ^ cf_o;
        end
        op_lsb_o  = opnd[0];
        op_bmsb_o = opnd[BYTE_W-1];
    end
endmodule

// File: rtl/sfu_flag_fix.sv
module sfu_flag_fix #(
    parameter int DATA_W = 16,
    parameter int MASK_W = 5
) (
    input  logic [MASK_W-1:0] cnt_i,
    input  logic              is_word_i,
    input  logic              dir_right_i,
    input  logic              op_lsb_i,
    input  logic              op_bmsb_i,
    input  logic              cf_norm_i,
    input  logic              of_norm_i,
    output logic              cf_o,
    output logic              of_o
);
    localparam int BYTE_W = DATA_W / 2;
    localparam logic [MASK_W-1:0] B1 = MASK_W'(BYTE_W);
    localparam logic [MASK_W-1:0] B2 = MASK_W'(2 * BYTE_W);
    localparam logic [MASK_W-1:0] B3 = MASK_W'(3 * BYTE_W);
    localparam logic [MASK_W-1:0] WW = MASK_W'(DATA_W);

    typedef enum logic [1:0] {
        CLS_INSIDE,
        CLS_MULT,
        CLS_FAR
    } cnt_class_e;

    cnt_class_e cls;

    always_comb begin
        if (is_word_i) begin
            if (cnt_i == WW)       cls = CLS_MULT;
            else if (cnt_i > WW)   cls = CLS_FAR;
            else                   cls = CLS_INSIDE;
        end else begin
            if (cnt_i == B1 || cnt_i == B2 || cnt_i == B3) cls = CLS_MULT;
            else if (cnt_i > B1)   cls = CLS_FAR;
            else                   cls = CLS_INSIDE;
        end
    end

    always_comb begin
        cf_o = cf_norm_i;
        of_o = of_norm_i;
        if (dir_right_i) begin
            // word right shifts keep plain semantics throughout
            if (!is_word_i) begin
                unique case (cls)
                    CLS_MULT: begin cf_o = op_bmsb_i; of_o = 1'b0; end
                    CLS_FAR:  begin cf_o = 1'b0;      of_o = 1'b0; end
                    default:  ;
                endcase
            end
        end else begin
            unique case (cls)
                CLS_MULT: begin cf_o = op_lsb_i; of_o = op_lsb_i; end
                CLS_FAR:  begin cf_o = 1'b0;     of_o = 1'b0;     end
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/sfu_status.sv
module sfu_status #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic              is_word_i,
    output logic              sf_o,
    output logic              zf_o,
    output logic              pf_o
);
    import sfu_pkg::*;
    localparam int BYTE_W = DATA_W / 2;

    always_comb begin
        sf_o = is_word_i ? result_i[DATA_W-1] : result_i[BYTE_W-1];
        zf_o = is_word_i ? (result_i == '0) : (result_i[BYTE_W-1:0] == '0);
        pf_o = even_parity8(result_i[7:0]);
    end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int MASK_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [DATA_W-1:0]          operand,
    input  logic                       is_word,
    input  logic                       dir_right,
    input  logic [CNT_W-1:0]           count,
    input  logic [sfu_pkg::FLAG_W-1:0] flags_in,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          result,
    output logic [sfu_pkg::FLAG_W-1:0] flags_out
);
    import sfu_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        sfu_flags_t        flags;
    } state_t;

    state_t state_d, state_q;

    logic [MASK_W-1:0] cnt;
    logic              cnt_nz;
    logic [DATA_W-1:0] sh_res;
    logic              cf_norm, of_norm, op_lsb, op_bmsb;
    logic              cf_fix, of_fix;
    logic              sf_new, zf_new, pf_new;

    sfu_count_reduce #(.CNT_W(CNT_W), .MASK_W(MASK_W)) i_reduce (
        .count_i   (count),
        .cnt_o     (cnt),
        .nonzero_o (cnt_nz)
    );

    sfu_shifter #(.DATA_W(DATA_W), .MASK_W(MASK_W)) i_shift (
        .operand_i   (operand),
        .is_word_i   (is_word),
        .dir_right_i (dir_right),
        .cnt_i       (cnt),
        .result_o    (sh_res),
        .cf_o        (cf_norm),
        .of_o        (of_norm),
        .op_lsb_o    (op_lsb),
        .op_bmsb_o   (op_bmsb)
    );

    sfu_flag_fix #(.DATA_W(DATA_W), .MASK_W(MASK_W)) i_fix (
        .cnt_i       (cnt),
        .is_word_i   (is_word),
        .dir_right_i (dir_right),
        .op_lsb_i    (op_lsb),
        .op_bmsb_i   (op_bmsb),
        .cf_norm_i   (cf_norm),
        .of_norm_i   (of_norm),
        .cf_o        (cf_fix),
        .of_o        (of_fix)
    );

    sfu_status #(.DATA_W(DATA_W)) i_status (
        .result_i  (sh_res),
        .is_word_i (is_word),
        .sf_o      (sf_new),
        .zf_o      (zf_new),
        .pf_o      (pf_new)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.result = sh_res;
            if (!cnt_nz) begin
                state_d.flags = sfu_flags_t'(flags_in);
            end else begin
                state_d.flags.cf = cf_fix;
                state_d.flags.of = of_fix;
                state_d.flags.af = 1'b1;
                state_d.flags.sf = sf_new;
                state_d.flags.zf = zf_new;
                state_d.flags.pf = pf_new;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.result;
    assign flags_out = state_q.flags;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int MASK_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] operand,
    input logic              is_word,
    input logic              dir_right,
    input logic [CNT_W-1:0]  count,
    input logic [5:0]        flags_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [5:0]        flags_out
);
    localparam int BYTE_W = DATA_W / 2;

    logic [MASK_W-1:0] m_cnt;
    logic [DATA_W-1:0] m_opnd;
    logic              m_byte_mult;

    assign m_cnt       = count[MASK_W-1:0];
    assign m_opnd      = is_word ? operand
                                 : {{(DATA_W-BYTE_W){1'b0}}, operand[BYTE_W-1:0]};
    assign m_byte_mult = (m_cnt == MASK_W'(BYTE_W)) || (m_cnt == MASK_W'(2*BYTE_W))
                      || (m_cnt == MASK_W'(3*BYTE_W));

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    a_r2_zero_count_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && m_cnt == '0) |=> (result == $past(m_opnd)) && (flags_out == $past(flags_in)));

    a_r3_wide_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(m_cnt) >= (is_word ? DATA_W : BYTE_W)) |=> result == '0);

    a_r3_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_word) |=> result[DATA_W-1:BYTE_W] == '0);

    a_r4_af_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && m_cnt != '0) |=> flags_out[2]);

    a_r5_zf_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && m_cnt != '0) |=> flags_out[3] == (result == '0));

    a_r7_byte_right_mult: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_word && dir_right && m_byte_mult)
        |=> (flags_out[0] == $past(operand[BYTE_W-1])) && !flags_out[5]);

    a_r8_byte_right_far: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_word && dir_right && !m_byte_mult && int'(m_cnt) > BYTE_W)
        |=> !flags_out[0] && !flags_out[5]);

    a_r9_byte_left_mult: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_word && !dir_right && m_byte_mult)
        |=> (flags_out[0] == $past(operand[0])) && (flags_out[5] == flags_out[0]));

    a_r10_byte_left_far: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_word && !dir_right && !m_byte_mult && int'(m_cnt) > BYTE_W)
        |=> !flags_out[0] && !flags_out[5]);

    a_r11_word_left_far: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_word && !dir_right && int'(m_cnt) > DATA_W)
        |=> !flags_out[0] && !flags_out[5]);

    a_r13_reset_idle: assert property (@(posedge clk)
        !rst_n |-> !out_valid && result == '0 && flags_out == '0);
endmodule

bind shift_flag_unit sfu_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MASK_W(MASK_W)) i_sfu_checker (.*);

// File: tb/test_shift_flag_unit.sv
module test_shift_flag_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [15:0] res;
        logic [5:0]  fl;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] operand = '0;
    logic        is_word = 1'b0;
    logic        dir_right = 1'b0;
    logic [7:0]  count = '0;
    logic [5:0]  flags_in = '0;
    logic        out_valid;
    logic [15:0] result;
    logic [5:0]  flags_out;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_flag_unit i_shift_flag_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .is_word(is_word), .dir_right(dir_right), .count(count),
        .flags_in(flags_in), .out_valid(out_valid), .result(result),
        .flags_out(flags_out)
    );

    // Reference model built from the requirements, one bit step at a time
    function automatic exp_t model(input logic [15:0] op, input bit w, input bit r,
                                   input logic [7:0] c_raw, input logic [5:0] fin);
        exp_t e;
        int unsigned wd = w ? 16 : 8;
        int unsigned c  = c_raw[4:0];
        logic [15:0] mask = w ? 16'hFFFF : 16'h00FF;
        logic [15:0] v = op & mask;
        logic msb0 = v[wd-1];
        logic lsb0 = v[0];
        logic cf = 1'b0;
        logic of;
        logic sf, zf, pf;
        if (c == 0) begin
            e.res = v; e.fl = fin;
            e.tag = (c_raw != 0) ? "R2 masked-zero" : "R2 zero-count";
            return e;
        end
        for (int i = 0; i < int'(c); i++) begin
            if (r) begin cf = v[0]; v = v >> 1; end
            else begin cf = v[wd-1]; v = (v << 1) & mask; end
        end
        of = r ? msb0 : (v[wd-1] ^ cf);
        e.tag = "R6 plain";
        if (!w && r) begin
            if (c == 8 || c == 16 || c == 24) begin cf = msb0; of = 1'b0; e.tag = "R7 byte-right-mult"; end
            else if (c > 8) begin cf = 1'b0; of = 1'b0; e.tag = "R8 byte-right-far"; end
        end else if (!w && !r) begin
            if (c == 8 || c == 16 || c == 24) begin cf = lsb0; of = cf; e.tag = "R9 byte-left-mult"; end
            else if (c > 8) begin cf = 1'b0; of = 1'b0; e.tag = "R10 byte-left-far"; end
        end else if (w && !r) begin
            if (c == 16) begin cf = lsb0; of = cf; e.tag = "R11 word-left-16"; end
            else if (c > 16) begin cf = 1'b0; of = 1'b0; e.tag = "R11 word-left-far"; end
        end
        if (c >= wd) e.tag = {e.tag, " R3"};
        e.tag = {e.tag, " R4 R5 R12"};
        sf = v[wd-1];
        zf = (v == 16'h0);
        pf = ~^v[7:0];
        e.res = v;
        e.fl  = {of, sf, zf, 1'b1, pf, cf};
        return e;
    endfunction

    task automatic drive(input logic [15:0] op, input bit w, input bit r,
                         input logic [7:0] c, input logic [5:0] fin);
        in_valid  = 1'b1;
        operand   = op;
        is_word   = w;
        dir_right = r;
        count     = c;
        flags_in  = fin;
        exp_q.push_back(model(op, w, r, c, fin));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: registered outputs, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R1: out_valid high with no pending item (result %h flags %b, expected none)",
                         result, flags_out);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (result !== e.res || flags_out !== e.fl) begin
                    fails++;
                    $display("FAIL %s: result %h flags %b, expected %h %b",
                             e.tag, result, flags_out, e.res, e.fl);
                end
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, actual hung, expected completion");
            summary();
        end
    end

    initial begin
        logic [15:0] ops [4] = '{16'h81C3, 16'h7E01, 16'h0080, 16'hFF7E};
        @(negedge clk);
        // R13: outputs held at zero during reset
        checks++;
        if (out_valid !== 1'b0 || result !== 16'h0 || flags_out !== 6'h0) begin
            fails++;
            $display("FAIL R13: reset outputs %b %h %b, expected 0 0000 000000",
                     out_valid, result, flags_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: zero count with upper count bits set, arbitrary incoming flags
        drive(16'hA5C3, 1'b0, 1'b0, 8'h00, 6'b101011);
        drive(16'hA5C3, 1'b1, 1'b1, 8'hE0, 6'b010100);
        drive(16'h1234, 1'b0, 1'b1, 8'h20, 6'b111111);
        // R2 masking: raw 0x48 reduces to 8, raw 0x31 reduces to 17
        drive(16'h0081, 1'b0, 1'b1, 8'h48, 6'h00);
        drive(16'h8001, 1'b1, 1'b0, 8'h31, 6'h3F);

        // Full sweep of reduced counts, both sizes and directions
        foreach (ops[k]) begin
            for (int c = 0; c < 32; c++) begin
                drive(ops[k], 1'b0, 1'b0, 8'(c), 6'b010101);
                drive(ops[k], 1'b0, 1'b1, 8'(c), 6'b101010);
                drive(ops[k], 1'b1, 1'b0, 8'(c), 6'b000000);
                drive(ops[k], 1'b1, 1'b1, 8'(c), 6'b111111);
            end
        end

        // Back-to-back issue without gaps (R1)
        in_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            operand = 16'h00F0 + 16'(i); is_word = i[0]; dir_right = i[1];
            count = 8'(i + 14); flags_in = 6'h00;
            exp_q.push_back(model(operand, is_word, dir_right, count, flags_in));
            @(negedge clk);
        end
        in_valid = 1'b0;

        repeat (4) @(negedge clk);
        // R1: all issued operations returned, and nothing is valid when idle
        checks++;
        if (exp_q.size() != 0 || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: pending %0d out_valid %b, expected 0 0", exp_q.size(), out_valid);
        end
        done = 1'b1;
        summary();
    end
endmodule